// File: doc/BRIEF.md
# Distributed Binary Semaphore Node

This block is the per-core slice of a set of binary semaphores that are shared across cores without any memory traffic. Each node keeps one token bit per semaphore. The value of a semaphore is the total of its token bits across all nodes, so there is at most one token for each index. That token may sit in any node. Local software issues take (P) and give (V) requests with a semaphore index. A take either succeeds at once or fails, and software retries a failed take by polling.

Tokens move between nodes as short messages on a simple receive and transmit port that stands in for a ring. A node that lacks a token sends a request for it. A node that holds a token and gets a request from another node hands the token over with a grant. Each node also keeps a per-index "lent" bit. This bit records that the node gave its token away, so a later give does not create a second token. The home node starts with every token after reset.

Top module: `sema_node`

## Requirements
- R1: After reset, a node whose CORE_ID equals HOME_CORE holds all NUM_SEM tokens, and a node with any other id holds none. Both outputs res_valid_o and tx_valid_o are 0 during reset.
- R2: A take (op_acq_i=1) on an index whose token is held locally succeeds and clears that token. In the cycle after the request, res_valid_o=1 and res_ok_o=1. A second take on the same index then fails.
- R3: A take on an index with no local token gives res_ok_o=0. In the next cycle it also emits a request message with tx_kind_o=0, tx_idx_o set to the index, and tx_peer_o set to CORE_ID.
- R4: An incoming request (rx_kind_i=0) for an index whose token is held locally comes from another core and is not claimed by a local take in the same cycle. The node clears its token, marks the index as lent, and in the next cycle emits a grant with tx_kind_o=1, tx_idx_o set to the index, and tx_peer_o set to the requester id.
- R5: An incoming request for an index whose token is not held, or one whose rx_peer_i equals CORE_ID, produces no message and changes no state.
- R6: An incoming grant (rx_kind_i=1) sets the local token and clears the lent mark. A take on the same index in the same cycle succeeds directly, consumes the token, and sends no request.
- R7: A give (op_acq_i=0) on an index whose token is not held and not lent sets the local token. res_ok_o=1 for every give.
- R8: A give on an index whose token is already held, or is marked as lent, leaves all token state unchanged.
- R9: When a local take and an incoming request hit the same index in the same cycle and the token is held, the local take wins. The take succeeds and no grant is sent.
- R10: Only one message leaves per cycle, and a grant takes priority over a request. A take that misses in the same cycle as an outgoing grant still reports failure, and its request is dropped.
- R11: Each index behaves independently under any mix of takes, gives, requests and grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Local operation present |
| op_acq_i | input | 1 | 1 = take (P), 0 = give (V) |
| op_idx_i | input | IDX_W | Semaphore index of local operation |
| rx_valid_i | input | 1 | Incoming message present |
| rx_kind_i | input | 1 | 0 = request, 1 = grant |
| rx_idx_i | input | IDX_W | Semaphore index of incoming message |
| rx_peer_i | input | PEER_W | Requester id carried by the incoming message |
| res_valid_o | output | 1 | Result of the previous cycle's operation |
| res_ok_o | output | 1 | Take succeeded (always 1 for a give) |
| tx_valid_o | output | 1 | Outgoing message present |
| tx_kind_o | output | 1 | 0 = request, 1 = grant |
| tx_idx_o | output | IDX_W | Semaphore index of outgoing message |
| tx_peer_o | output | PEER_W | Own id for a request, destination id for a grant |

## Verification
Two functions share a single cycle in this design. The first is the local take path. The second is the handling of incoming messages, which can claim the same token or the single transmit slot. The bench drives a take and an incoming request on the same held index in one cycle and expects a successful take with no grant. It also drives a missing take alongside a grantable request on another index and expects only the grant on the transmit port. It then sends a grant together with a take on the same index and expects the take to succeed without any request. A random phase limited to a few indices and peers causes these collisions often, and a reference model in the bench judges each cycle.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic {
    MSG_REQ   = 1'b0,
    MSG_GRANT = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/sema_token_bank.sv
module sema_token_bank
  import sema_pkg::*;
#(
  parameter int NUM_SEM   = 64,
  parameter int PEER_W    = 4,
  parameter int CORE_ID   = 0,
  parameter int HOME_CORE = 0,
  localparam int IDX_W    = $clog2(NUM_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_acq_i,
  input  logic [IDX_W-1:0]  op_idx_i,
  input  logic              rx_valid_i,
  input  logic              rx_kind_i,
  input  logic [IDX_W-1:0]  rx_idx_i,
  input  logic [PEER_W-1:0] rx_peer_i,
  output logic              p_hit_o,
  output logic              p_miss_o,
  output logic              gnt_fire_o
);
  localparam logic [NUM_SEM-1:0] RST_TOK = (CORE_ID == HOME_CORE) ? '1 : '0;
  localparam logic [PEER_W-1:0]  SELF    = PEER_W'(CORE_ID);

  logic [NUM_SEM-1:0] tok_q, tok_d;
  logic [NUM_SEM-1:0] away_q, away_d;

  logic rx_req, rx_gnt, gnt_same, loc_bit, claim, v_set;

  always_comb begin
    rx_req   = rx_valid_i && (rx_kind_i == MSG_REQ);
    rx_gnt   = rx_valid_i && (rx_kind_i == MSG_GRANT);
    gnt_same = rx_gnt && (rx_idx_i == op_idx_i);
    // incoming grant is usable by a take in the same cycle
    loc_bit  = tok_q[op_idx_i] | gnt_same;
    p_hit_o  = op_valid_i && op_acq_i && loc_bit;
    p_miss_o = op_valid_i && op_acq_i && !loc_bit;
    claim    = op_valid_i && op_acq_i && (op_idx_i == rx_idx_i);
    gnt_fire_o = rx_req && tok_q[rx_idx_i] && !claim && (rx_peer_i != SELF);
    v_set    = op_valid_i && !op_acq_i && !tok_q[op_idx_i]
               && !away_q[op_idx_i] && !gnt_same;
  end

  always_comb begin
    tok_d  = tok_q;
    away_d = away_q;
    if (rx_gnt) begin
      tok_d[rx_idx_i]  = 1'b1;
      away_d[rx_idx_i] = 1'b0;
    end
    if (gnt_fire_o) begin
      tok_d[rx_idx_i]  = 1'b0;
      away_d[rx_idx_i] = 1'b1;
    end
    if (p_hit_o) tok_d[op_idx_i] = 1'b0;
    if (v_set)   tok_d[op_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q  <= RST_TOK;
      away_q <= '0;
    end else begin
      tok_q  <= tok_d;
      away_q <= away_d;
    end
  end

  AST_RESET_TOKENS: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> tok_q == RST_TOK && away_q == '0) else $error("reset"); // R1

  AST_TAKE_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_acq_i && tok_q[op_idx_i] |=> !tok_q[$past(op_idx_i)]) else $error("take"); // R2

  AST_GRANT_LENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req && tok_q[rx_idx_i] && !claim && rx_peer_i != SELF
    |=> !tok_q[$past(rx_idx_i)] && away_q[$past(rx_idx_i)]) else $error("grant"); // R4

  AST_GIVE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !op_acq_i && (tok_q[op_idx_i] || away_q[op_idx_i]) && !rx_valid_i
    |=> tok_q == $past(tok_q) && away_q == $past(away_q)) else $error("give"); // R8

  AST_HELD_OR_LENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_q & away_q) == '0) else $error("held and lent"); // R11
endmodule

// File: rtl/sema_tx_arb.sv
module sema_tx_arb
  import sema_pkg::*;
#(
  parameter int NUM_SEM = 64,
  parameter int PEER_W  = 4,
  parameter int CORE_ID = 0,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_v_i,
  input  logic [IDX_W-1:0]  gnt_idx_i,
  input  logic [PEER_W-1:0] gnt_peer_i,
  input  logic              req_v_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  output logic              tx_valid_o,
  output logic              tx_kind_o,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic [PEER_W-1:0] tx_peer_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_kind_o  <= MSG_REQ;
      tx_idx_o   <= '0;
      tx_peer_o  <= '0;
    end else begin
      tx_valid_o <= gnt_v_i || req_v_i;
      // grant wins the slot; a losing request is dropped, software retries
      if (gnt_v_i) begin
        tx_kind_o <= MSG_GRANT;
        tx_idx_o  <= gnt_idx_i;
        tx_peer_o <= gnt_peer_i;
      end else if (req_v_i) begin
        tx_kind_o <= MSG_REQ;
        tx_idx_o  <= req_idx_i;
        tx_peer_o <= PEER_W'(CORE_ID);
      end
    end
  end

  AST_GRANT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_v_i |=> tx_valid_o && tx_kind_o == MSG_GRANT && tx_idx_o == $past(gnt_idx_i)) else $error("prio"); // R10

  AST_REQ_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_v_i && !gnt_v_i |=> tx_valid_o && tx_kind_o == MSG_REQ
    && tx_peer_o == PEER_W'(CORE_ID)) else $error("req"); // R3

  AST_TX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_v_i && !req_v_i |=> !tx_valid_o) else $error("idle"); // R5
endmodule

// File: rtl/sema_node.sv
module sema_node
  import sema_pkg::*;
#(
  parameter int NUM_SEM   = 64,
  parameter int PEER_W    = 4,
  parameter int CORE_ID   = 0,
  parameter int HOME_CORE = 0,
  localparam int IDX_W    = $clog2(NUM_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_acq_i,
  input  logic [IDX_W-1:0]  op_idx_i,
  input  logic              rx_valid_i,
  input  logic              rx_kind_i,
  input  logic [IDX_W-1:0]  rx_idx_i,
  input  logic [PEER_W-1:0] rx_peer_i,
  output logic              res_valid_o,
  output logic              res_ok_o,
  output logic              tx_valid_o,
  output logic              tx_kind_o,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic [PEER_W-1:0] tx_peer_o
);
  logic p_hit, p_miss, gnt_fire;

  sema_token_bank #(
    .NUM_SEM(NUM_SEM), .PEER_W(PEER_W), .CORE_ID(CORE_ID), .HOME_CORE(HOME_CORE)
  ) i_bank (
    .clk_i, .rst_ni,
    .op_valid_i, .op_acq_i, .op_idx_i,
    .rx_valid_i, .rx_kind_i, .rx_idx_i, .rx_peer_i,
    .p_hit_o(p_hit), .p_miss_o(p_miss), .gnt_fire_o(gnt_fire)
  );

  sema_tx_arb #(
    .NUM_SEM(NUM_SEM), .PEER_W(PEER_W), .CORE_ID(CORE_ID)
  ) i_arb (
    .clk_i, .rst_ni,
    .gnt_v_i(gnt_fire), .gnt_idx_i(rx_idx_i), .gnt_peer_i(rx_peer_i),
    .req_v_i(p_miss), .req_idx_i(op_idx_i),
    .tx_valid_o, .tx_kind_o, .tx_idx_o, .tx_peer_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_ok_o    <= 1'b0;
    end else begin
      res_valid_o <= op_valid_i;
      res_ok_o    <= op_valid_i && (!op_acq_i || p_hit);
    end
  end

  AST_RESULT_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> res_valid_o) else $error("res"); // R2

  AST_MISS_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_miss |=> res_valid_o && !res_ok_o) else $error("miss"); // R3
endmodule

// File: tb/test_sema_node.sv
module test_sema_node;
  localparam int NUM_SEM = 64;
  localparam int PEER_W  = 4;
  localparam int IDX_W   = $clog2(NUM_SEM);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, op_acq = 0, rx_valid = 0, rx_kind = 0;
  logic [IDX_W-1:0] op_idx = '0, rx_idx = '0;
  logic [PEER_W-1:0] rx_peer = '0;
  logic res_valid, res_ok, tx_valid, tx_kind;
  logic [IDX_W-1:0] tx_idx;
  logic [PEER_W-1:0] tx_peer;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [NUM_SEM-1:0] m_tok, m_away;

  always #4 clk = ~clk;

  sema_node i_sema_node (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_valid), .op_acq_i(op_acq), .op_idx_i(op_idx),
    .rx_valid_i(rx_valid), .rx_kind_i(rx_kind), .rx_idx_i(rx_idx), .rx_peer_i(rx_peer),
    .res_valid_o(res_valid), .res_ok_o(res_ok),
    .tx_valid_o(tx_valid), .tx_kind_o(tx_kind), .tx_idx_o(tx_idx), .tx_peer_o(tx_peer)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit ov, input bit oa, input int oi,
                      input bit rv, input bit rk, input int ri, input int rp,
                      input string tag);
    bit gin, hit, miss, claim, gout, vset;
    @(negedge clk);
    op_valid = ov; op_acq = oa; op_idx = IDX_W'(oi);
    rx_valid = rv; rx_kind = rk; rx_idx = IDX_W'(ri); rx_peer = PEER_W'(rp);
    gin   = ov && rv && rk && (ri == oi);
    hit   = ov && oa && (m_tok[oi] || gin);
    miss  = ov && oa && !(m_tok[oi] || gin);
    claim = ov && oa && (oi == ri);
    gout  = rv && !rk && m_tok[ri] && !claim && (rp != 0);
    vset  = ov && !oa && !m_tok[oi] && !m_away[oi] && !gin;
    if (rv && rk) begin m_tok[ri] = 1'b1; m_away[ri] = 1'b0; end
    if (gout) begin m_tok[ri] = 1'b0; m_away[ri] = 1'b1; end
    if (hit) m_tok[oi] = 1'b0;
    if (vset) m_tok[oi] = 1'b1;
    @(posedge clk); #2;
    chk(tag, "res_valid", res_valid, ov);
    chk(tag, "res_ok", res_ok, ov && (!oa || hit));
    chk(tag, "tx_valid", tx_valid, gout || miss);
    if (gout) begin
      chk(tag, "grant kind", tx_kind, 1);
      chk(tag, "grant idx", tx_idx, ri);
      chk(tag, "grant peer", tx_peer, rp);
    end else if (miss) begin
      chk(tag, "req kind", tx_kind, 0);
      chk(tag, "req idx", tx_idx, oi);
      chk(tag, "req peer", tx_peer, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5E3A_0001));
    m_tok = '1; m_away = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "res_valid in reset", res_valid, 0);
    chk("R1", "tx_valid in reset", tx_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1, 1, 63, 0, 0, 0, 0, "R1");            // home node holds top index
    step(1, 1, 5, 0, 0, 0, 0, "R2");             // take with token
    step(1, 1, 5, 0, 0, 0, 0, "R3");             // second take misses, request out
    step(0, 0, 0, 1, 0, 9, 3, "R4");             // remote request, grant out
    step(1, 1, 9, 0, 0, 0, 0, "R4");             // token gone
    step(1, 0, 9, 0, 0, 0, 0, "R8");             // give while lent
    step(1, 1, 9, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 9, 2, "R5");             // request, no token
    step(0, 0, 0, 1, 0, 10, 0, "R5");            // own request returning
    step(1, 1, 10, 0, 0, 0, 0, "R5");            // token 10 still here
    step(1, 1, 9, 1, 1, 9, 3, "R6");             // grant + take same cycle
    step(1, 1, 9, 0, 0, 0, 0, "R6");
    step(1, 0, 5, 0, 0, 0, 0, "R7");             // give, not lent
    step(1, 1, 5, 0, 0, 0, 0, "R7");
    step(1, 0, 20, 0, 0, 0, 0, "R8");            // give while held
    step(1, 1, 20, 0, 0, 0, 0, "R8");
    step(1, 1, 20, 0, 0, 0, 0, "R8");
    step(1, 1, 30, 1, 0, 30, 4, "R9");           // local take beats remote request
    step(1, 1, 30, 0, 0, 0, 0, "R9");
    step(1, 1, 5, 1, 0, 40, 6, "R10");           // miss + grant: grant wins
    step(1, 1, 40, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 4000; i++) begin
      int oi = $urandom % 8;
      int ri = $urandom % 8;
      step($urandom % 4 != 0, $urandom % 2, oi,
           $urandom % 3 == 0, $urandom % 2, ri, $urandom % 4, "R11");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R11");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule